// File: doc/BRIEF.md
# Block-Throttled Outbound Word Source

This block sits between user logic that produces 32-bit words and a host that pulls them out in fixed-size blocks. User logic pushes words with a write enable whenever it likes. The words wait in an internal first-in first-out store until the host collects them. The host is the master of the transfer. It watches a ready output, announces each block with a single-cycle block strobe, and then issues read strobes. It may leave gaps between read strobes. Each read strobe is answered with the next stored word on the following clock cycle.

Ready is a promise that a whole block can be read without running dry. It is high only when no block is in progress and the store holds at least `BLK_WORDS` words. It drops on the cycle after a block strobe. It is decided again once that block's last read has been taken. The store holds `DEPTH_BLKS` blocks. A write that arrives while the store is full is discarded and reported on a one-cycle overflow flag. A read that finds the store empty returns zero and sets a sticky underflow flag.

Top module: `blk_pipe_source`

## Requirements
- R1: After a synchronous active-high reset, `blk_ready`, `ovf_flag`, `unf_flag` and `rd_data` are all 0.
- R2: Words leave in the order they were written. The word for a read strobe sampled at clock edge N is on `rd_data` after edge N. It stays there until the next read strobe is sampled.
- R3: When no block is open, `blk_ready` is 1 exactly when the store holds at least `BLK_WORDS` words (default 256). A write sampled at edge N counts toward ready after edge N.
- R4: A block strobe sampled at edge N opens a block, and `blk_ready` is 0 after edge N. It stays 0 until `BLK_WORDS` read strobes of that block have been sampled. After the edge of the last of those reads, ready is decided by R3 again.
- R5: Read strobes within a block may be separated by any number of idle cycles. Order and one-cycle latency are kept.
- R6: The store holds `BLK_WORDS*DEPTH_BLKS` words. A write sampled while it is full is discarded and leaves the stored words unchanged. `ovf_flag` is 1 for exactly the one cycle after that edge.
- R7: A read strobe sampled while the store is empty makes `rd_data` 0 after that edge. It also sets `unf_flag`, which stays 1 until reset.
- R8: A write and a read sampled on the same edge with the store neither empty nor full both take effect. The read returns the oldest word, and the new word joins the back of the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by user logic and host side |
| rst | input | 1 | Synchronous active-high reset |
| usr_wr_en | input | 1 | User write enable |
| usr_wr_data | input | DATA_W | User word to store |
| hst_rd | input | 1 | Host read strobe |
| hst_blk_stb | input | 1 | Host single-cycle block start strobe |
| rd_data | output | DATA_W | Word returned the cycle after a read strobe |
| blk_ready | output | 1 | A full block can be read |
| ovf_flag | output | 1 | One-cycle pulse after a discarded write |
| unf_flag | output | 1 | Sticky: a read found the store empty |

## Verification
The bench plays the host. It puts random idle gaps between reads and checks every returned word against a model queue, exactly one cycle after its strobe. It also checks that the value holds through the gaps, so a design that presents data a cycle late or lets it drift while idle is caught. The ready threshold is probed one word below and at the block size, to catch an off-by-one compare. Ready is also checked while a block is open with two blocks buffered, to catch a design that does not hold ready low for the whole block. A write into a full store is followed by draining both blocks. This exposes a design that overwrites the oldest word or lets the rejected word in. Simultaneous write and read, and reads from an empty store, catch level miscounting and a non-sticky or missing underflow.

// File: rtl/blkpipe_pkg.sv
package blkpipe_pkg;
  typedef enum logic {
    BLK_IDLE = 1'b0,
    BLK_OPEN = 1'b1
  } blk_state_e;
endpackage

// File: rtl/blkpipe_ram.sv
// Simple dual-port storage, written so that a block RAM with a registered
// read port can be inferred.
module blkpipe_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  parameter int PTR_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/blkpipe_level.sv
// Pointers and fill level of the store; gates writes on full, reads on empty.
module blkpipe_level #(
  parameter int DEPTH = 512,
  parameter int PTR_W = 9,
  parameter int LVL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic             rd_req,
  output logic             wr_fire,
  output logic             rd_fire,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] level_n,
  output logic             full,
  output logic             empty
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam bit               POW2     = (DEPTH & (DEPTH - 1)) == 0;

  logic [PTR_W-1:0] wptr_inc, rptr_inc;

  assign full    = (level == FULL_LVL);
  assign empty   = (level == '0);
  assign wr_fire = wr_req && !full;
  assign rd_fire = rd_req && !empty;

  generate
    if (POW2) begin : g_wrap_free
      assign wptr_inc = wptr + 1'b1;
      assign rptr_inc = rptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wptr_inc = (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
      assign rptr_inc = (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
    end
  endgenerate

  always_comb begin
    unique case ({wr_fire, rd_fire})
      2'b10:   level_n = level + 1'b1;
      2'b01:   level_n = level - 1'b1;
      default: level_n = level;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_fire) wptr <= wptr_inc;
      if (rd_fire) rptr <= rptr_inc;
      level <= level_n;
    end
  end
endmodule

// File: rtl/blkpipe_blocker.sv
// Tracks the open block and produces the registered ready output.
module blkpipe_blocker
  import blkpipe_pkg::*;
#(
  parameter int BLK_WORDS = 256,
  parameter int LVL_W     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_stb,
  input  logic             rd_stb,
  input  logic [LVL_W-1:0] level_n,
  output logic             blk_open,
  output logic             ready
);
  localparam int               LEFT_W  = $clog2(BLK_WORDS + 1);
  localparam logic [LEFT_W-1:0] LEFT_FULL = LEFT_W'(BLK_WORDS);
  localparam logic [LEFT_W-1:0] LEFT_ONE  = LEFT_W'(1);
  localparam logic [LVL_W-1:0]  BLK_LVL   = LVL_W'(BLK_WORDS);

  blk_state_e        st, st_n;
  logic [LEFT_W-1:0] left, left_n;
  logic              ready_n;

  always_comb begin
    st_n   = st;
    left_n = left;
    if (st == BLK_OPEN && rd_stb) begin
      left_n = left - 1'b1;
      if (left == LEFT_ONE) st_n = BLK_IDLE;
    end
    if (blk_stb) begin
      st_n   = BLK_OPEN;
      left_n = LEFT_FULL;
    end
    ready_n = (st_n == BLK_IDLE) && (level_n >= BLK_LVL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= BLK_IDLE;
      left  <= '0;
      ready <= 1'b0;
    end else begin
      st    <= st_n;
      left  <= left_n;
      ready <= ready_n;
    end
  end

  assign blk_open = (st == BLK_OPEN);
endmodule

// File: rtl/blk_pipe_source.sv
module blk_pipe_source #(
  parameter int DATA_W     = 32,
  parameter int BLK_WORDS  = 256,
  parameter int DEPTH_BLKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              usr_wr_en,
  input  logic [DATA_W-1:0] usr_wr_data,
  input  logic              hst_rd,
  input  logic              hst_blk_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              blk_ready,
  output logic              ovf_flag,
  output logic              unf_flag
);
  localparam int DEPTH = BLK_WORDS * DEPTH_BLKS;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic              wr_fire, rd_fire, full, empty, blk_open;
  logic [PTR_W-1:0]  wptr, rptr;
  logic [LVL_W-1:0]  level, level_n;
  logic [DATA_W-1:0] mem_q;
  logic              zero_q;

  blkpipe_level #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_level (
    .clk(clk), .rst(rst), .wr_req(usr_wr_en), .rd_req(hst_rd),
    .wr_fire(wr_fire), .rd_fire(rd_fire), .wptr(wptr), .rptr(rptr),
    .level(level), .level_n(level_n), .full(full), .empty(empty)
  );

  blkpipe_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_ram (
    .clk(clk), .rst(rst), .we(wr_fire), .waddr(wptr), .wdata(usr_wr_data),
    .re(rd_fire), .raddr(rptr), .rdata(mem_q)
  );

  blkpipe_blocker #(.BLK_WORDS(BLK_WORDS), .LVL_W(LVL_W)) u_blocker (
    .clk(clk), .rst(rst), .blk_stb(hst_blk_stb), .rd_stb(hst_rd),
    .level_n(level_n), .blk_open(blk_open), .ready(blk_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      zero_q   <= 1'b1;
    end else begin
      ovf_flag <= usr_wr_en && full;
      if (hst_rd && empty) unf_flag <= 1'b1;
      if (hst_rd) zero_q <= empty;
    end
  end

  assign rd_data = zero_q ? '0 : mem_q;
endmodule

// File: rtl/blk_pipe_source_chk.sv
module blk_pipe_source_chk #(
  parameter int DATA_W    = 32,
  parameter int BLK_WORDS = 256,
  parameter int DEPTH     = 512,
  parameter int LVL_W     = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              usr_wr_en,
  input logic              hst_rd,
  input logic              hst_blk_stb,
  input logic [DATA_W-1:0] rd_data,
  input logic              blk_ready,
  input logic              ovf_flag,
  input logic              unf_flag,
  input logic [LVL_W-1:0]  level,
  input logic              blk_open
);
  localparam logic [LVL_W-1:0] BLK_LVL  = LVL_W'(BLK_WORDS);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  // R3: ready implies a whole block is buffered
  a_r3_ready_has_block: assert property (@(posedge clk) disable iff (rst)
    blk_ready |-> (level >= BLK_LVL));

  // R3: idle with a block buffered implies ready
  a_r3_block_gives_ready: assert property (@(posedge clk) disable iff (rst)
    (!blk_open && level >= BLK_LVL) |-> blk_ready);

  // R4: no ready while a block is open
  a_r4_open_not_ready: assert property (@(posedge clk) disable iff (rst)
    blk_open |-> !blk_ready);

  // R4: strobe drops ready on the next cycle
  a_r4_stb_drops_ready: assert property (@(posedge clk) disable iff (rst)
    hst_blk_stb |=> !blk_ready);

  // R6: write into full store pulses overflow and does not grow the level
  a_r6_full_write_flag: assert property (@(posedge clk) disable iff (rst)
    (usr_wr_en && level == FULL_LVL) |=> ovf_flag);

  a_r6_level_bounded: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LVL);

  // R7: empty read returns zero and underflow is sticky
  a_r7_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (hst_rd && level == '0) |=> (rd_data == '0 && unf_flag));

  a_r7_unf_sticky: assert property (@(posedge clk) disable iff (rst)
    unf_flag |=> unf_flag);

  // R2: without a read the returned word holds
  a_r2_data_holds: assert property (@(posedge clk) disable iff (rst)
    !hst_rd |=> $stable(rd_data));
endmodule

bind blk_pipe_source blk_pipe_source_chk #(
  .DATA_W(DATA_W), .BLK_WORDS(BLK_WORDS), .DEPTH(DEPTH), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .usr_wr_en(usr_wr_en), .hst_rd(hst_rd),
  .hst_blk_stb(hst_blk_stb), .rd_data(rd_data), .blk_ready(blk_ready),
  .ovf_flag(ovf_flag), .unf_flag(unf_flag), .level(level), .blk_open(blk_open)
);

// File: tb/blk_pipe_source_tb.sv
`timescale 1ns/1ps
module blk_pipe_source_tb;
  localparam int DATA_W = 32;
  localparam int BLK    = 256;
  localparam int NBLK   = 2;
  localparam int DEPTH  = BLK * NBLK;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              usr_wr_en = 1'b0;
  logic [DATA_W-1:0] usr_wr_data = '0;
  logic              hst_rd = 1'b0;
  logic              hst_blk_stb = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              blk_ready, ovf_flag, unf_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [DATA_W-1:0] model_q[$];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  blk_pipe_source #(.DATA_W(DATA_W), .BLK_WORDS(BLK), .DEPTH_BLKS(NBLK)) u_dut (
    .clk(clk), .rst(rst), .usr_wr_en(usr_wr_en), .usr_wr_data(usr_wr_data),
    .hst_rd(hst_rd), .hst_blk_stb(hst_blk_stb), .rd_data(rd_data),
    .blk_ready(blk_ready), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; usr_wr_en = 1'b0; hst_rd = 1'b0; hst_blk_stb = 1'b0;
    model_q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // writes n words base+i on consecutive cycles; ends at the negedge after the last edge
  task automatic write_words(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      usr_wr_en = 1'b1;
      usr_wr_data = base + i;
      if (model_q.size() < DEPTH) model_q.push_back(base + i);
      @(negedge clk);
    end
    usr_wr_en = 1'b0;
  endtask

  task automatic strobe_block();
    hst_blk_stb = 1'b1;
    @(negedge clk);
    hst_blk_stb = 1'b0;
    chk(blk_ready == 1'b0, "R4 ready low after block strobe", blk_ready, 0);
  endtask

  // reads n words with random gaps; checks order, one-cycle latency, hold
  task automatic read_words(input int n, input bit in_block, input bit rand_gaps);
    logic [31:0] exp, last;
    int gap;
    for (int i = 0; i < n; i++) begin
      hst_rd = 1'b1;
      exp = (model_q.size() > 0) ? model_q.pop_front() : 32'h0;
      @(negedge clk);
      hst_rd = 1'b0;
      chk(rd_data == exp, "R2 word order and latency", rd_data, exp);
      last = rd_data;
      step_lfsr();
      gap = (rand_gaps && lfsr[1:0] == 2'b00) ? int'(lfsr[4:2]) : 0;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk(rd_data == last, "R5 data held across gap", rd_data, last);
        if (in_block && i != n - 1)
          chk(blk_ready == 1'b0, "R4 ready low inside block", blk_ready, 0);
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(blk_ready == 1'b0, "R1 ready at reset", blk_ready, 0);
    chk(ovf_flag == 1'b0, "R1 ovf at reset", ovf_flag, 0);
    chk(unf_flag == 1'b0, "R1 unf at reset", unf_flag, 0);
    chk(rd_data == '0, "R1 data at reset", rd_data, 0);
  endtask

  task automatic t_one_block();
    do_reset();
    write_words(BLK - 1, 32'h1000_0000);
    chk(blk_ready == 1'b0, "R3 not ready one word short", blk_ready, 0);
    write_words(1, 32'h1000_0000 + BLK - 1);
    chk(blk_ready == 1'b1, "R3 ready at block size", blk_ready, 1);
    strobe_block();
    read_words(BLK, 1'b1, 1'b1);
    chk(blk_ready == 1'b0, "R4 ready low after block drained", blk_ready, 0);
    chk(unf_flag == 1'b0, "R7 no underflow on normal block", unf_flag, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    write_words(DEPTH, 32'h2000_0000);
    chk(blk_ready == 1'b1, "R3 ready when full", blk_ready, 1);
    chk(ovf_flag == 1'b0, "R6 no ovf while filling", ovf_flag, 0);
    write_words(1, 32'hDEAD_BEEF);
    chk(ovf_flag == 1'b1, "R6 ovf pulse after full write", ovf_flag, 1);
    @(negedge clk);
    chk(ovf_flag == 1'b0, "R6 ovf lasts one cycle", ovf_flag, 0);
    strobe_block();
    read_words(BLK, 1'b1, 1'b1);
    chk(blk_ready == 1'b1, "R4 ready re-decided after block", blk_ready, 1);
    strobe_block();
    read_words(BLK, 1'b1, 1'b0);
    chk(blk_ready == 1'b0, "R4 ready low when drained", blk_ready, 0);
  endtask

  task automatic t_underflow();
    chk(unf_flag == 1'b0, "R7 unf clear before empty read", unf_flag, 0);
    read_words(1, 1'b0, 1'b0);
    chk(rd_data == '0, "R7 zero data on empty read", rd_data, 0);
    chk(unf_flag == 1'b1, "R7 unf set", unf_flag, 1);
    write_words(1, 32'h3000_0001);
    read_words(1, 1'b0, 1'b0);
    chk(unf_flag == 1'b1, "R7 unf sticky", unf_flag, 1);
  endtask

  task automatic t_simul();
    do_reset();
    write_words(3, 32'h4000_0000);
    hst_rd = 1'b1; usr_wr_en = 1'b1; usr_wr_data = 32'h4000_00AA;
    @(negedge clk);
    hst_rd = 1'b0; usr_wr_en = 1'b0;
    chk(rd_data == 32'h4000_0000, "R8 simultaneous read returns oldest", rd_data, 32'h4000_0000);
    void'(model_q.pop_front());
    model_q.push_back(32'h4000_00AA);
    chk(blk_ready == 1'b0, "R3 ready low with few words", blk_ready, 0);
    read_words(3, 1'b0, 1'b0);
    chk(rd_data == 32'h4000_00AA, "R8 simultaneous write kept", rd_data, 32'h4000_00AA);
    read_words(1, 1'b0, 1'b0);
    chk(rd_data == '0, "R8 level exact after simultaneous ops", rd_data, 0);
  endtask

  initial begin
    t_reset();
    t_one_block();
    t_overflow();
    t_underflow();
    t_simul();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule